// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five software localities owns a shared register interface of a security device. Each locality sees its own 4 KiB window of the register space, chosen by the upper address bits. At the bottom of every window sits a one-byte access register. Through that register a caller can ask for ownership, check whether it is the current owner, see whether other localities are waiting, and hand ownership back.

An arbiter inside the block keeps one pending flag per locality and a single owner. When no locality owns the interface and the device has finished initialising, the highest-numbered waiting locality becomes owner on the next clock. The block tells neighbouring logic who the owner is. It raises a one-cycle pulse each time ownership changes. It also qualifies writes aimed at the other registers of each window, so that only the owner's writes go through.

The register port is a plain byte-wide port: address, write enable, write data, and combinational read data. It has no back-pressure. A write takes effect on the clock edge at which the write enable is high.

Top module: `loc_arb`

## Requirements
- R1: The locality is `reg_addr[14:12]`, and its access register is at offset 0 (`reg_addr[11:0] == 0`). A locality number of 5, 6 or 7 reads 0 and its writes change nothing. Any offset other than 0 also reads 0 on `reg_rdata`.
- R2: Access register bit 7 is the valid bit. It reads 0 after reset until `init_done` has been sampled high at a clock edge. From the next cycle on it reads 1, even if `init_done` later falls.
- R3: Access register bit 5 reads 1 only when the addressed locality is the current owner. `owner_valid` and `owner_loc` report the owner. `owner_loc` has meaning only while `owner_valid` is 1.
- R4: Writing bit 1 = 1 to a locality's access register makes that locality pending from the next cycle. The write is ignored when the addressed locality is the owner at that edge, including a write that sets bit 5 and bit 1 together.
- R5: While there is no owner, the valid bit reads 1 and at least one locality is pending, the highest-numbered pending locality becomes owner at the next edge and its pending flag clears. Before initialisation no locality is ever granted.
- R6: Access register bit 2 reads 1 when some locality other than the addressed one is pending.
- R7: Writing bit 5 = 1 to the owner's access register clears `owner_valid` at that edge. The same write from a locality that is not the owner has no effect. Any pending locality is granted at the following edge.
- R8: `loc_change` is high for exactly the first cycle in which a new owner, or the absence of an owner, is visible, and it is low otherwise.
- R9: `wr_allow` is high in a cycle exactly when `reg_wr_en` is high, the address has a valid locality and a nonzero offset, and that locality is the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Device initialisation complete |
| reg_addr | input | 15 | Register address; bits 14:12 select the locality |
| reg_wr_en | input | 1 | Write strobe for the current address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| owner_loc | output | 3 | Number of the owning locality |
| owner_valid | output | 1 | An owner exists |
| loc_change | output | 1 | One-cycle pulse when ownership changes |
| wr_allow | output | 1 | Write to a non-access register from the owner |

## Verification
The bench sweeps every subset of localities 1 to 4 queued behind a holding locality 0, and then follows the chain of releases.

- A wrong priority encoder would show up here as a grant order that is not descending.
- A pending flag that is not cleared on grant would hand ownership back to the same locality a second time.

It also targets the less obvious cases:

- A request issued before initialisation must not be granted; a design without the valid gate grants it at once.
- A request, or a request combined with a release, from the current owner must leave no pending flag; a design that gets this wrong regrants the locality that just released.
- A release from a locality that does not own the interface must be ignored; a design that gets this wrong drops the real owner.
- Out-of-range localities and nonzero offsets must read 0; a design that gets this wrong aliases onto locality 0 to 4.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // Bit positions inside each locality's access register.
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_WAIT_BIT   = 2;
  localparam int ACC_ASK_BIT    = 1;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int LOC_LSB = 12,
  localparam int ADDR_W = LOC_LSB + LOC_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output logic              loc_ok,
  output logic              is_access,
  output logic [NUM_LOC-1:0] loc_sel
);
  assign loc       = addr[ADDR_W-1:LOC_LSB];
  assign loc_ok    = int'(loc) < NUM_LOC;
  assign is_access = (addr[LOC_LSB-1:0] == '0);

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
    assign loc_sel[g] = (loc == LOC_W'(g));
  end
endmodule

// File: rtl/loc_arb_pending.sv
module loc_arb_pending #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] set_vec,
  input  logic [NUM_LOC-1:0] clr_vec,
  output logic [NUM_LOC-1:0] pend
);
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend[g] <= 1'b0;
      else if (clr_vec[g]) pend[g] <= 1'b0;  // grant wins over a same-cycle request
      else if (set_vec[g]) pend[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/loc_arb_owner.sv
module loc_arb_owner #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] pend,
  input  logic               ready,
  input  logic               release_req,
  output logic [LOC_W-1:0]   owner,
  output logic               valid,
  output logic               change,
  output logic [NUM_LOC-1:0] grant_vec
);
  logic [LOC_W-1:0] pick;
  logic             any;
  logic             grant;

  // Highest-numbered pending locality wins: later loop passes overwrite.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pend[i]) begin
        pick = LOC_W'(i);
        any  = 1'b1;
      end
    end
  end

  assign grant = !valid && ready && any;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_gnt
    assign grant_vec[g] = grant && (pick == LOC_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner  <= '0;
      valid  <= 1'b0;
      change <= 1'b0;
    end else begin
      change <= grant || (valid && release_req);
      if (grant) begin
        owner <= pick;
        valid <= 1'b1;
      end else if (release_req) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/loc_arb.sv
module loc_arb #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int LOC_LSB = 12,
  localparam int ADDR_W = LOC_LSB + LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [LOC_W-1:0]  owner_loc,
  output logic              owner_valid,
  output logic              loc_change,
  output logic              wr_allow
);
  import loc_arb_pkg::*;

  logic [LOC_W-1:0]   loc;
  logic               loc_ok;
  logic               is_access;
  logic [NUM_LOC-1:0] loc_sel;
  logic [NUM_LOC-1:0] pend;
  logic [NUM_LOC-1:0] ask_vec;
  logic [NUM_LOC-1:0] grant_vec;
  logic               init_q;
  logic               acc_wr;
  logic               is_owner;
  logic               rel;

  loc_arb_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .LOC_LSB(LOC_LSB)) u_dec (
    .addr      (reg_addr),
    .loc       (loc),
    .loc_ok    (loc_ok),
    .is_access (is_access),
    .loc_sel   (loc_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b0;
    else        init_q <= init_q | init_done;
  end

  assign acc_wr   = reg_wr_en && loc_ok && is_access;
  assign is_owner = owner_valid && (owner_loc == loc);
  assign rel      = acc_wr && reg_wdata[ACC_ACTIVE_BIT] && is_owner;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_ask
    assign ask_vec[g] = acc_wr && reg_wdata[ACC_ASK_BIT] && !is_owner && loc_sel[g];
  end

  loc_arb_pending #(.NUM_LOC(NUM_LOC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (ask_vec),
    .clr_vec (grant_vec),
    .pend    (pend)
  );

  loc_arb_owner #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_own (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend),
    .ready       (init_q),
    .release_req (rel),
    .owner       (owner_loc),
    .valid       (owner_valid),
    .change      (loc_change),
    .grant_vec   (grant_vec)
  );

  always_comb begin
    reg_rdata = '0;
    if (loc_ok && is_access) begin
      reg_rdata[ACC_VALID_BIT]  = init_q;
      reg_rdata[ACC_ACTIVE_BIT] = is_owner;
      reg_rdata[ACC_WAIT_BIT]   = |(pend & ~loc_sel);
    end
  end

  assign wr_allow = reg_wr_en && loc_ok && !is_access && is_owner;
endmodule

// File: rtl/loc_arb_checker.sv
module loc_arb_checker #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int LOC_LSB = 12,
  localparam int ADDR_W = LOC_LSB + LOC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [LOC_W-1:0]  owner_loc,
  input logic              owner_valid,
  input logic              loc_change,
  input logic              wr_allow
);
  logic seen_q;
  logic [LOC_W-1:0] a_loc;
  logic a_off0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_q | init_done;
  end

  assign a_loc  = reg_addr[ADDR_W-1:LOC_LSB];
  assign a_off0 = (reg_addr[LOC_LSB-1:0] == '0);

  a_r2_valid_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] |-> seen_q);

  a_r3_active_is_owner: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |-> (owner_valid && owner_loc == a_loc));

  a_r5_grant_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_valid) |-> seen_q);

  a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owner_valid) |-> $past(reg_wr_en && a_off0 && reg_wdata[5] && a_loc == owner_loc));

  a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid != $past(owner_valid) || (owner_valid && owner_loc != $past(owner_loc)))
      |-> loc_change);

  a_r8_pulse_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    loc_change |-> (owner_valid != $past(owner_valid) || owner_loc != $past(owner_loc)));

  a_r9_allow_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> (owner_valid && owner_loc == a_loc && !a_off0));
endmodule

bind loc_arb loc_arb_checker #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .LOC_LSB(LOC_LSB)) u_chk (.*);

// File: tb/loc_arb_bench.sv
module loc_arb_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        init_done = 0;
  logic [14:0] reg_addr = '0;
  logic        reg_wr_en = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [2:0]  owner_loc;
  logic        owner_valid;
  logic        loc_change;
  logic        wr_allow;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state derived from the requirements
  bit       m_v = 0;
  int       m_o = 0;
  bit [4:0] m_p = '0;
  bit       m_i = 0;
  bit       m_chg = 0;

  loc_arb u_loc_arb (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_acc(input int l);
    logic [7:0] r;
    r = '0;
    r[7] = m_i;
    r[5] = m_v && (m_o == l);
    r[2] = |(m_p & ~(5'(1) << l));
    return r;
  endfunction

  task automatic step(input bit we, input int loc, input int off, input logic [7:0] d);
    bit nv; int no; bit [4:0] np; int hi;
    @(negedge clk);
    reg_addr  = 15'((loc << 12) | off);
    reg_wr_en = we;
    reg_wdata = d;
    #1;
    chk("R9 wr_allow", {7'd0, wr_allow},
        {7'd0, we && loc < 5 && off != 0 && m_v && m_o == loc});
    @(posedge clk);
    nv = m_v; no = m_o; np = m_p;
    if (we && loc < 5 && off == 0) begin
      if (d[5] && m_v && m_o == loc) nv = 0;
      if (d[1] && !(m_v && m_o == loc)) np[loc] = 1;
    end
    if (!m_v && m_i && m_p != 0) begin
      hi = 0;
      for (int i = 0; i < 5; i++) if (m_p[i]) hi = i;
      nv = 1; no = hi; np[hi] = 0;
    end
    m_chg = (nv != m_v) || (nv && no != m_o);
    m_v = nv; m_o = no; m_p = np;
    m_i = m_i | init_done;
    #1;
    reg_wr_en = 0;
    chk("R3/R5 owner_valid", {7'd0, owner_valid}, {7'd0, m_v});
    if (m_v) chk("R5 owner_loc", {5'd0, owner_loc}, 8'(m_o));
    chk("R8 loc_change", {7'd0, loc_change}, {7'd0, m_chg});
    for (int l = 0; l < 5; l++) begin
      reg_addr = 15'(l << 12);
      #0.5;
      chk("R2/R3/R6 access read", reg_rdata, exp_acc(l));
    end
    reg_addr = 15'(5 << 12);
    #0.5 chk("R1 out-of-range locality reads 0", reg_rdata, 8'h00);
    reg_addr = 15'(((m_o % 5) << 12) | 12'h018);
    #0.5 chk("R1 nonzero offset reads 0", reg_rdata, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset owner_valid", {7'd0, owner_valid}, 8'd0);
    chk("R8 reset loc_change", {7'd0, loc_change}, 8'd0);
    chk("R2 reset valid bit", reg_rdata, 8'h00);
    @(negedge clk) rst_n = 1;

    // R5: request before initialisation is held, not granted
    step(1, 3, 0, 8'h02);
    idle(3);
    chk("R5 no grant before init", {7'd0, owner_valid}, 8'd0);
    init_done = 1;
    idle(3);
    chk("R5 granted after init", {5'd0, owner_loc}, 8'd3);
    init_done = 0;   // R2: valid stays set

    // R4: owner re-requesting is ignored
    step(1, 3, 0, 8'h02);
    #0.2 reg_addr = 15'(1 << 12);
    #0.1 chk("R4 owner request leaves no pending", reg_rdata, 8'h80);

    // R7: release from a non-owner has no effect
    step(1, 1, 0, 8'h20);
    chk("R7 non-owner release ignored", {7'd0, owner_valid}, 8'd1);

    // R9 / R1: non-access writes
    step(1, 3, 12'h024, 8'h55);
    step(1, 2, 12'h024, 8'h55);
    step(1, 5, 0, 8'h22);
    step(1, 6, 12'h024, 8'h22);

    // R7: owner releases; R4: combined release+request leaves nothing pending
    step(1, 3, 0, 8'h20);
    idle(2);
    step(1, 4, 0, 8'h02);
    idle(2);
    step(1, 4, 0, 8'h22);
    idle(3);
    chk("R4 combined release+request no regrant", {7'd0, owner_valid}, 8'd0);

    // Sweep: every subset of localities 1..4 queued behind locality 0
    for (int mask = 0; mask < 16; mask++) begin
      step(1, 0, 0, 8'h02);
      idle(2);
      for (int l = 1; l < 5; l++) if (mask[l-1]) step(1, l, 0, 8'h02);
      idle(1);
      step(1, 0, 0, 8'h20);
      idle(1);
      for (int k = 0; k < 6; k++) begin
        if (m_v) step(1, m_o, 0, 8'h20);
        idle(1);
      end
      chk("R5 sweep drained", {3'd0, m_p}, 8'd0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule